// File: doc/BRIEF.md
# Element-Width Saturating Adder Lane

This block adds two 64-bit operands as a packed vector of equal-width elements. The element width is picked per operation from four choices (8, 16, 32 or 64 bits). Each element is an independent integer add. A carry-in is added into the least significant bit of every element. An optional saturation mode then clamps each element using its exact, one-bit-wider sum. The carry-out of each element is taken at the selected width, never at bit 64.

For every element the block reports a carry flag and an overflow flag. It also reports a 4-bit condition field, built from a signed compare of the final element value against zero plus a summary-overflow bit. That bit covers only the current operation. Results are captured one cycle after a valid strobe, and an output-valid strobe marks them. The block suits a vector datapath in which one scalar add is repeated across narrower lanes.

Top module: `ewsat_lane`

## Requirements
- R1: `ew_sel` picks the element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Element i occupies bits [i*W +: W] of the operands and the result. With saturation off, each element holds its own sum modulo 2^W, and no carry crosses between elements.
- R2: `carry_in` is added into the least significant bit of every element at every width.
- R3: `carry_flags[i]` is bit W of the unsigned sum of element i, whatever the saturation mode. Slots at or above 64/W read 0.
- R4: With `sat_sel`=1 (unsigned), the operands are unsigned. When the carry-out is set, the element becomes all ones.
- R5: With `sat_sel`=2 (signed), the operands are two's complement. A positive overflow clamps to 2^(W-1)-1, and a negative overflow clamps to -2^(W-1).
- R6: With `sat_sel`=3 (signed-to-unsigned), the operands are signed. A negative exact sum becomes 0, and a non-negative exact sum passes unchanged.
- R7: `ovf_flags[i]` is the signed overflow in modes 0 and 2, the carry-out in mode 1, and the negative-sum condition in mode 3. Slots at or above 64/W read 0.
- R8: The condition field of element i is `cond_fields[4i+3:4i]`. Bit 3 is LT and bit 2 is GT, both from a signed compare of the final element value against zero. Bit 1 is EQ (element is zero). Bit 0 is SO and equals `ovf_flags[i]`. Slots at or above 64/W read 0.
- R9: SO reflects only the operation that produced it. An operation without overflow that follows one with overflow shows SO=0.
- R10: A cycle with `in_valid` high updates every output at the next clock edge and raises `out_valid` for one cycle. While `in_valid` is low, results and flags hold and `out_valid` is 0.
- R11: Synchronous reset clears `out_valid`, the result, all flags and all condition fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| carry_in | input | 1 | Carry added to every element |
| ew_sel | input | 2 | Element width code |
| sat_sel | input | 2 | Saturation mode code |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| sum_out | output | 64 | Packed element results |
| carry_flags | output | 8 | Per-element carry-out at element width |
| ovf_flags | output | 8 | Per-element overflow or clamp indication |
| cond_fields | output | 32 | Per-element LT/GT/EQ/SO fields |

## Verification
Within one element, the saturation clamp and the raw carry-out at width W are reported in the same cycle. Mixed vectors provoke this: one lane overflows while its neighbours do not, as in an unsigned 16-bit add with three saturating halves or a signed-to-unsigned byte add with a negative lane that also carries. The bench judges that the carry bit shows bit W of the unclamped sum while the result shows the clamp and SO follows the mode's overflow rule. Operations are also issued back to back, with an overflowing operation followed immediately by a clean one, so the SO bit is shown not to carry over.

// File: rtl/ewsat_pkg.sv
package ewsat_pkg;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_UNS  = 2'd1,
    SAT_SGN  = 2'd2,
    SAT_S2U  = 2'd3
  } sat_mode_e;

  // bit positions inside one condition nibble
  localparam int CF_SO = 0;
  localparam int CF_EQ = 1;
  localparam int CF_GT = 2;
  localparam int CF_LT = 3;
  localparam int CF_W  = 4;

endpackage

// File: rtl/ewsat_elem.sv
module ewsat_elem
  import ewsat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  input  sat_mode_e       mode,
  output logic [W-1:0]    res,
  output logic            carry,
  output logic            ovf,
  output logic [CF_W-1:0] cond
);

  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] usum;
  logic [W:0] ssum;
  logic       sovf;
  logic       is_zero;

  // exact sums, one bit wider than the element
  assign usum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign ssum = {a[W-1], a} + {b[W-1], b} + {{W{1'b0}}, cin};
  assign sovf = ssum[W] ^ ssum[W-1];

  assign carry = usum[W];

  always_comb begin
    unique case (mode)
      SAT_UNS: begin
        res = usum[W] ? UMAX : usum[W-1:0];
        ovf = usum[W];
      end
      SAT_SGN: begin
        res = sovf ? (ssum[W] ? SMIN : SMAX) : ssum[W-1:0];
        ovf = sovf;
      end
      SAT_S2U: begin
        res = ssum[W] ? '0 : ssum[W-1:0];
        ovf = ssum[W];
      end
      default: begin
        res = usum[W-1:0];
        ovf = sovf;
      end
    endcase
  end

  assign is_zero      = (res == '0);
  assign cond[CF_LT]  = res[W-1];
  assign cond[CF_EQ]  = is_zero;
  assign cond[CF_GT]  = ~res[W-1] & ~is_zero;
  assign cond[CF_SO]  = ovf;

endmodule

// File: rtl/ewsat_bank.sv
module ewsat_bank
  import ewsat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ELEM_W = 8,
  parameter int SLOTS  = 8
) (
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  input  logic                  cin,
  input  sat_mode_e             mode,
  output logic [DATA_W-1:0]     res,
  output logic [SLOTS-1:0]      carry,
  output logic [SLOTS-1:0]      ovf,
  output logic [CF_W*SLOTS-1:0] cond
);

  localparam int NEL = DATA_W / ELEM_W;

  for (genvar e = 0; e < NEL; e++) begin : g_el
    ewsat_elem #(.W(ELEM_W)) u_elem (
      .a    (a[e*ELEM_W +: ELEM_W]),
      .b    (b[e*ELEM_W +: ELEM_W]),
      .cin  (cin),
      .mode (mode),
      .res  (res[e*ELEM_W +: ELEM_W]),
      .carry(carry[e]),
      .ovf  (ovf[e]),
      .cond (cond[e*CF_W +: CF_W])
    );
  end

  for (genvar e = NEL; e < SLOTS; e++) begin : g_idle
    assign carry[e]            = 1'b0;
    assign ovf[e]              = 1'b0;
    assign cond[e*CF_W +: CF_W] = '0;
  end

endmodule

// File: rtl/ewsat_select.sv
module ewsat_select
  import ewsat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SLOTS  = 8,
  parameter int NUM_W  = 4,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]                  sel,
  input  logic [NUM_W-1:0][DATA_W-1:0]      res_in,
  input  logic [NUM_W-1:0][SLOTS-1:0]       carry_in,
  input  logic [NUM_W-1:0][SLOTS-1:0]       ovf_in,
  input  logic [NUM_W-1:0][CF_W*SLOTS-1:0]  cond_in,
  output logic [DATA_W-1:0]                 res,
  output logic [SLOTS-1:0]                  carry,
  output logic [SLOTS-1:0]                  ovf,
  output logic [CF_W*SLOTS-1:0]             cond
);

  always_comb begin
    // codes beyond the last width fall back to the widest element
    res   = res_in[NUM_W-1];
    carry = carry_in[NUM_W-1];
    ovf   = ovf_in[NUM_W-1];
    cond  = cond_in[NUM_W-1];
    for (int k = 0; k < NUM_W; k++) begin
      if (int'(sel) == k) begin
        res   = res_in[k];
        carry = carry_in[k];
        ovf   = ovf_in[k];
        cond  = cond_in[k];
      end
    end
  end

endmodule

// File: rtl/ewsat_lane.sv
module ewsat_lane
  import ewsat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8,
  parameter int NUM_W  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic [DATA_W-1:0]                op_a,
  input  logic [DATA_W-1:0]                op_b,
  input  logic                             carry_in,
  input  logic [$clog2(NUM_W)-1:0]         ew_sel,
  input  logic [1:0]                       sat_sel,
  output logic                             out_valid,
  output logic [DATA_W-1:0]                sum_out,
  output logic [DATA_W/BASE_W-1:0]         carry_flags,
  output logic [DATA_W/BASE_W-1:0]         ovf_flags,
  output logic [4*(DATA_W/BASE_W)-1:0]     cond_fields
);

  localparam int SLOTS = DATA_W / BASE_W;
  localparam int SEL_W = $clog2(NUM_W);

  sat_mode_e mode;
  assign mode = sat_mode_e'(sat_sel);

  logic [NUM_W-1:0][DATA_W-1:0]     bank_res;
  logic [NUM_W-1:0][SLOTS-1:0]      bank_carry;
  logic [NUM_W-1:0][SLOTS-1:0]      bank_ovf;
  logic [NUM_W-1:0][CF_W*SLOTS-1:0] bank_cond;

  for (genvar k = 0; k < NUM_W; k++) begin : g_bank
    ewsat_bank #(
      .DATA_W(DATA_W),
      .ELEM_W(BASE_W << k),
      .SLOTS (SLOTS)
    ) u_bank (
      .a    (op_a),
      .b    (op_b),
      .cin  (carry_in),
      .mode (mode),
      .res  (bank_res[k]),
      .carry(bank_carry[k]),
      .ovf  (bank_ovf[k]),
      .cond (bank_cond[k])
    );
  end

  logic [DATA_W-1:0]     sel_res;
  logic [SLOTS-1:0]      sel_carry;
  logic [SLOTS-1:0]      sel_ovf;
  logic [CF_W*SLOTS-1:0] sel_cond;

  ewsat_select #(
    .DATA_W(DATA_W),
    .SLOTS (SLOTS),
    .NUM_W (NUM_W),
    .SEL_W (SEL_W)
  ) u_sel (
    .sel     (ew_sel),
    .res_in  (bank_res),
    .carry_in(bank_carry),
    .ovf_in  (bank_ovf),
    .cond_in (bank_cond),
    .res     (sel_res),
    .carry   (sel_carry),
    .ovf     (sel_ovf),
    .cond    (sel_cond)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      sum_out     <= '0;
      carry_flags <= '0;
      ovf_flags   <= '0;
      cond_fields <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_out     <= sel_res;
        carry_flags <= sel_carry;
        ovf_flags   <= sel_ovf;
        cond_fields <= sel_cond;
      end
    end
  end

endmodule

// File: rtl/ewsat_lane_chk.sv
module ewsat_lane_chk #(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8,
  parameter int NUM_W  = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic [DATA_W-1:0]            op_a,
  input logic [DATA_W-1:0]            op_b,
  input logic                         carry_in,
  input logic [$clog2(NUM_W)-1:0]     ew_sel,
  input logic [1:0]                   sat_sel,
  input logic                         out_valid,
  input logic [DATA_W-1:0]            sum_out,
  input logic [DATA_W/BASE_W-1:0]     carry_flags,
  input logic [DATA_W/BASE_W-1:0]     ovf_flags,
  input logic [4*(DATA_W/BASE_W)-1:0] cond_fields
);

  localparam int WIDE = NUM_W - 1;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(sum_out) && $stable(cond_fields))); // R10

  AST_WIDE_SLOTS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int'(ew_sel) == WIDE) |=> (carry_flags[DATA_W/BASE_W-1:1] == '0)); // R3

  AST_UNS_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_sel == 2'd1 && int'(ew_sel) == WIDE)
      |=> (!carry_flags[0] || sum_out == {DATA_W{1'b1}})); // R4

  AST_SGN_KEEPS_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_sel == 2'd2 && int'(ew_sel) == WIDE && op_a[DATA_W-1] == op_b[DATA_W-1])
      |=> (sum_out[DATA_W-1] == $past(op_a[DATA_W-1]))); // R5

  AST_S2U_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_sel == 2'd3 && int'(ew_sel) == WIDE && op_a[DATA_W-1] && op_b[DATA_W-1])
      |=> (sum_out == '0)); // R6

  AST_ONE_COMPARE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(cond_fields[3:1]) == 1)); // R8

endmodule

bind ewsat_lane ewsat_lane_chk #(
  .DATA_W(DATA_W),
  .BASE_W(BASE_W),
  .NUM_W (NUM_W)
) u_chk (.*);

// File: tb/ewsat_lane_test.sv
`timescale 1ns/1ps
module ewsat_lane_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] op_a, op_b;
  logic        carry_in;
  logic [1:0]  ew_sel, sat_sel;
  logic        out_valid;
  logic [63:0] sum_out;
  logic [7:0]  carry_flags, ovf_flags;
  logic [31:0] cond_fields;

  always #10 clk = ~clk;

  ewsat_lane uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .ew_sel(ew_sel), .sat_sel(sat_sel),
    .out_valid(out_valid), .sum_out(sum_out), .carry_flags(carry_flags),
    .ovf_flags(ovf_flags), .cond_fields(cond_fields)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  ew;
    logic [1:0]  sat;
    logic        cin;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] sum;
    logic [7:0]  cy;
    logic [7:0]  ov;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    // R1: plain 64-bit add
    '{8'd1, 2'd3, 2'd0, 1'b0, 64'h1, 64'h2, 64'h3, 8'h00, 8'h00},
    // R3: carry at bit 64 with carry-in, wraps to zero
    '{8'd3, 2'd3, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 8'h01, 8'h00},
    // R1: byte lanes, carry of lane 0 does not reach lane 1
    '{8'd1, 2'd0, 2'd0, 1'b0, 64'h0102_0304_0506_07FF, 64'h0101_0101_0101_0101,
      64'h0203_0405_0607_0800, 8'h01, 8'h00},
    // R2: carry-in lands in every byte lane
    '{8'd2, 2'd0, 2'd0, 1'b1, 64'h0102_0304_0506_07FF, 64'h0101_0101_0101_0101,
      64'h0304_0506_0708_0901, 8'h01, 8'h00},
    // R4: unsigned 16-bit clamps
    '{8'd4, 2'd1, 2'd1, 1'b0, 64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFF_0001,
      64'hFFFF_FFFF_FFFF_1235, 8'h0E, 8'h0E},
    // R5: signed 32-bit clamps both ways, carry still raw
    '{8'd5, 2'd2, 2'd2, 1'b0, 64'h7FFF_FFF0_8000_0000, 64'h0000_0020_FFFF_FFFF,
      64'h7FFF_FFFF_8000_0000, 8'h01, 8'h03},
    // R6: signed-to-unsigned bytes
    '{8'd6, 2'd0, 2'd3, 1'b0, 64'h807F_F010_0000_0000, 64'h807F_08F0_0000_0000,
      64'h00FE_0000_0000_0000, 8'h90, 8'hA0},
    // R5: carry-in pushes max positive over the edge
    '{8'd5, 2'd3, 2'd2, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0,
      64'h7FFF_FFFF_FFFF_FFFF, 8'h00, 8'h01},
    // R7: wrap mode reports signed overflow
    '{8'd7, 2'd3, 2'd0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1,
      64'h8000_0000_0000_0000, 8'h00, 8'h01},
    // R9: clean op right after an overflow, negative result
    '{8'd9, 2'd3, 2'd0, 1'b0, 64'h5, 64'hFFFF_FFFF_FFFF_FFF9,
      64'hFFFF_FFFF_FFFF_FFFE, 8'h00, 8'h00},
    // R4: unsigned 32-bit with carry-in
    '{8'd4, 2'd2, 2'd1, 1'b1, 64'hFFFF_FFFF_0000_0010, 64'h0000_0000_0000_0005,
      64'hFFFF_FFFF_0000_0016, 8'h02, 8'h02}
  };

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(input string what, input int rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // R8 model: nibble {LT,GT,EQ,SO} per element, idle slots zero
  function automatic logic [31:0] cond_model(input logic [1:0] ew, input logic [63:0] s,
                                             input logic [7:0] ov);
    logic [31:0] r = '0;
    int w = 8 << ew;
    int n = 64 / w;
    for (int i = 0; i < n; i++) begin
      logic msb = s[i*w + w - 1];
      logic z = 1'b1;
      for (int k = 0; k < w; k++) if (s[i*w + k]) z = 1'b0;
      r[i*4 +: 4] = {msb, ~msb & ~z, z, ov[i]};
    end
    return r;
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
    carry_in = 1'b0; ew_sel = '0; sat_sel = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("reset out_valid", 11, {63'd0, out_valid}, 64'd0);
    chk("reset sum", 11, sum_out, 64'd0);
    chk("reset flags", 11, {48'd0, carry_flags, ovf_flags}, 64'd0);
    chk("reset cond", 11, {32'd0, cond_fields}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      in_valid = 1'b1;
      op_a = VEC[v].a; op_b = VEC[v].b; carry_in = VEC[v].cin;
      ew_sel = VEC[v].ew; sat_sel = VEC[v].sat;
      @(negedge clk);
      chk($sformatf("vec %0d out_valid", v), 10, {63'd0, out_valid}, 64'd1);
      chk($sformatf("vec %0d sum", v), int'(VEC[v].rq), sum_out, VEC[v].sum);
      chk($sformatf("vec %0d carry", v), 3, {56'd0, carry_flags}, {56'd0, VEC[v].cy});
      chk($sformatf("vec %0d ovf", v), 7, {56'd0, ovf_flags}, {56'd0, VEC[v].ov});
      chk($sformatf("vec %0d cond", v), 8, {32'd0, cond_fields},
          {32'd0, cond_model(VEC[v].ew, VEC[v].sum, VEC[v].ov)});
    end

    // R10: idle cycles hold results while inputs change
    held = sum_out;
    in_valid = 1'b0;
    op_a = 64'h1234_5678_9ABC_DEF0; op_b = 64'h1111_1111_1111_1111;
    ew_sel = 2'd1; sat_sel = 2'd0;
    @(negedge clk);
    chk("idle out_valid low", 10, {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("idle sum held", 10, sum_out, held);
    chk("idle flags held", 10, {48'd0, carry_flags, ovf_flags}, {48'd0, 8'h02, 8'h02});

    // R9: SO set then cleared by the next clean byte add
    in_valid = 1'b1; ew_sel = 2'd0; sat_sel = 2'd2; carry_in = 1'b0;
    op_a = 64'h0000_0000_0000_007F; op_b = 64'h0000_0000_0000_0001;
    @(negedge clk);
    chk("byte sat SO set", 9, {60'd0, cond_fields[3:0]}, 64'h5); // GT + SO
    op_a = 64'h0000_0000_0000_0010; op_b = 64'h0000_0000_0000_0001;
    @(negedge clk);
    chk("byte SO cleared", 9, {60'd0, cond_fields[3:0]}, 64'h4); // GT only
    chk("byte sum", 1, sum_out, 64'h11);

    // R11: reset mid-run clears registered state
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("rerun reset sum", 11, sum_out, 64'd0);
    chk("rerun reset cond", 11, {32'd0, cond_fields}, 64'd0);
    report();
  end

endmodule